// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block buffers 18-bit words between two clock domains that may be unrelated or driven by one shared clock. It stores up to 2048 words. A producer pushes one word per write-clock edge while its write strobe is high. A consumer pops one word per read-clock edge while its read strobe is high. The popped word appears on a registered output, and an output-enable input gates that output to all zeros.

Five status outputs report the fill level. Empty and almost-empty are formed in the read domain. Half, almost-full and full are formed in the write domain. Each side compares its own binary pointer with the other side's pointer, which arrives as a Gray code through a two-stage synchroniser. The almost-empty and almost-full margins come from a small load port in the write domain, and the read side takes the empty margin through a synchroniser. A rewind input on the read side moves the read pointer back to the first word written since reset, so that stored data can be played out again.

Top module: `twoclk_flag_fifo`

## Requirements
- R1: The buffer holds exactly 2048 words of 18 bits. After 2048 accepted writes with no reads, `full` is 1.
- R2: On each `wr_clk` rising edge where `wr_en` is 1 and `full` is 0, one word from `wr_data` is stored and the write pointer advances by one.
- R3: On each `rd_clk` rising edge where `rd_en` is 1, `empty` is 0 and `rtx` is 0, the oldest word is removed and appears on `rd_data` after that edge. Words leave in the order they were written, and back-to-back reads are supported.
- R4: While `rd_oe` is 0, `rd_data` is all zeros. While `rd_oe` is 1, `rd_data` shows the most recently read word, which is zero after reset.
- R5: After reset, `empty`=1, `aempty`=1, `half`=0, `afull`=0, `full`=0 and `rd_data`=0. `empty` is 1 exactly when the read-side word count is zero.
- R6: `aempty` is 1 when the read-side word count is at or below the empty margin.
- R7: `afull` is 1 when the free space (2048 minus the write-side word count) is at or below the full margin. `full` is 1 when the write-side count is 2048.
- R8: `half` is 1 when the write-side word count is greater than 1024.
- R9: A `wr_clk` edge with `cfg_ld`=1 loads the 11-bit `cfg_val` into the empty margin when `cfg_sel`=0, or into the full margin when `cfg_sel`=1. Both margins are 127 after reset.
- R10: A write attempted while `full` is 1 is ignored. No word is stored and the write pointer does not move.
- R11: A read attempted while `empty` is 1 is ignored. The read pointer does not move and `rd_data` keeps its value.
- R12: A `rd_clk` edge with `rtx`=1 returns the read pointer to the first word written since reset. Later reads replay the words in their original order. This is valid only while no more than 2048 words have been written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Push one word this write-clock edge |
| wr_data | input | 18 | Word to push |
| cfg_ld | input | 1 | Load a margin this write-clock edge |
| cfg_sel | input | 1 | Margin select: 0 = empty margin, 1 = full margin |
| cfg_val | input | 11 | Margin value |
| rd_en | input | 1 | Pop one word this read-clock edge |
| rd_oe | input | 1 | Output enable for rd_data |
| rtx | input | 1 | Rewind the read pointer to the first stored word |
| rd_data | output | 18 | Popped word, or zero while rd_oe is low |
| empty | output | 1 | No words visible to the reader |
| aempty | output | 1 | Word count at or below the empty margin |
| half | output | 1 | Word count above 1024 |
| afull | output | 1 | Free space at or below the full margin |
| full | output | 1 | 2048 words stored |

## Verification
The bench walks the count across each flag threshold one word at a time: 4 and 5 against an empty margin of 4, 1024 and 1025 for `half`, and 2039, 2040 and 2048 against a full margin of 8. A comparison off by one, or a flag taken from the wrong domain's count, would switch a flag one word early or late. It pushes into a full buffer and pops from an empty one, then reads back the whole sequence. A guard that failed to hold a pointer would show up as a stray word, a skipped word or a non-empty buffer at the end. It checks the 127 reset margins without loading them, and it replays data after a rewind. A rewind that missed the first stored word, or left the reader seeing zero words, would give wrong replay data or a stuck `empty`.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic {
    SEL_EMPTY_MARGIN = 1'b0,
    SEL_FULL_MARGIN  = 1'b1
  } margin_sel_e;
endpackage

// File: rtl/tcf_sync.sv
module tcf_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/tcf_mem.sv
module tcf_mem #(
  parameter int DW = 18,
  parameter int AW = 11
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n)  rq <= '0;
    else if (re)  rq <= store[raddr];
  end
endmodule

// File: rtl/tcf_wr_ctl.sv
module tcf_wr_ctl
  import tcf_pkg::*;
#(
  parameter int          AW      = 11,
  parameter int unsigned OFF_DEF = 127
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          cfg_ld,
  input  margin_sel_e   cfg_sel,
  input  logic [AW-1:0] cfg_val,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          wr_do,
  output logic [AW-1:0] ae_off,
  output logic          full,
  output logic          afull,
  output logic          half
);
  localparam logic [AW:0]   FULL_CNT = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0]   HALF_CNT = {2'b01, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] OFF_RST  = AW'(OFF_DEF);

  logic [AW:0]   rbin_s, count, free_sp, wbin_d, wgray_d;
  logic [AW-1:0] af_q, af_d, ae_d;

  for (genvar i = 0; i <= AW; i++) begin : g_g2b
    assign rbin_s[i] = ^rgray_s[AW:i];
  end

  // fill level and flags from registered state
  always_comb begin
    count   = wbin - rbin_s;
    free_sp = FULL_CNT - count;
    full    = (count == FULL_CNT);
    half    = (count > HALF_CNT);
    afull   = (free_sp <= {1'b0, af_q});
    wr_do   = wr_en & ~full;
    wbin_d  = wbin + {{AW{1'b0}}, wr_do};
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_comb begin
    af_d = af_q;
    ae_d = ae_off;
    if (cfg_ld) begin
      if (cfg_sel == SEL_FULL_MARGIN) af_d = cfg_val;
      else                            ae_d = cfg_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      af_q   <= OFF_RST;
      ae_off <= OFF_RST;
    end else begin
      if (wr_do) begin
        wbin  <= wbin_d;
        wgray <= wgray_d;
      end
      if (cfg_ld) begin
        af_q   <= af_d;
        ae_off <= ae_d;
      end
    end
  end
endmodule

// File: rtl/tcf_rd_ctl.sv
module tcf_rd_ctl #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rtx,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off_s,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          rd_do,
  output logic          empty,
  output logic          aempty
);
  logic [AW:0] wbin_s, count, rbin_d, rgray_d;
  logic        ptr_ce;

  for (genvar i = 0; i <= AW; i++) begin : g_g2b
    assign wbin_s[i] = ^wgray_s[AW:i];
  end

  always_comb begin
    count   = wbin_s - rbin;
    empty   = (count == '0);
    aempty  = (count <= {1'b0, ae_off_s});
    rd_do   = rd_en & ~empty & ~rtx;
    ptr_ce  = rd_do | rtx;
    rbin_d  = rtx ? '0 : rbin + 1'b1;
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (ptr_ce) begin
      rbin  <= rbin_d;
      rgray <= rgray_d;
    end
  end
endmodule

// File: rtl/twoclk_flag_fifo.sv
module twoclk_flag_fifo #(
  parameter int          DW      = 18,
  parameter int          AW      = 11,
  parameter int unsigned OFF_DEF = 127
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          cfg_ld,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_val,
  input  logic          rd_en,
  input  logic          rd_oe,
  input  logic          rtx,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          aempty,
  output logic          half,
  output logic          afull,
  output logic          full
);
  localparam logic [AW-1:0] OFF_RST = AW'(OFF_DEF);

  logic          wrst_n, rrst_n, wr_do, rd_do;
  logic [AW:0]   w_bin, w_gray, r_bin, r_gray, w_gray_s, r_gray_s;
  logic [AW-1:0] ae_off_w, ae_off_r;
  logic [DW-1:0] rq;

  tcf_sync #(.W(1), .RST_VAL(1'b0)) u_wrst (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  tcf_sync #(.W(1), .RST_VAL(1'b0)) u_rrst (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  tcf_sync #(.W(AW+1), .RST_VAL('0)) u_r2w (
    .clk(wr_clk), .rst_n(wrst_n), .d(r_gray), .q(r_gray_s));
  tcf_sync #(.W(AW+1), .RST_VAL('0)) u_w2r (
    .clk(rd_clk), .rst_n(rrst_n), .d(w_gray), .q(w_gray_s));
  tcf_sync #(.W(AW), .RST_VAL(OFF_RST)) u_aeoff (
    .clk(rd_clk), .rst_n(rrst_n), .d(ae_off_w), .q(ae_off_r));

  tcf_wr_ctl #(.AW(AW), .OFF_DEF(OFF_DEF)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .wr_en(wr_en), .cfg_ld(cfg_ld),
    .cfg_sel(tcf_pkg::margin_sel_e'(cfg_sel)), .cfg_val(cfg_val),
    .rgray_s(r_gray_s), .wbin(w_bin), .wgray(w_gray), .wr_do(wr_do),
    .ae_off(ae_off_w), .full(full), .afull(afull), .half(half));

  tcf_rd_ctl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .rd_en(rd_en), .rtx(rtx),
    .wgray_s(w_gray_s), .ae_off_s(ae_off_r), .rbin(r_bin), .rgray(r_gray),
    .rd_do(rd_do), .empty(empty), .aempty(aempty));

  tcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(wr_do), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
    .rd_clk(rd_clk), .rrst_n(rrst_n), .re(rd_do), .raddr(r_bin[AW-1:0]),
    .rq(rq));

  assign rd_data = rd_oe ? rq : '0;
endmodule

// File: rtl/tcf_chk.sv
module tcf_chk #(
  parameter int AW = 11
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        wrst_n,
  input logic        rrst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        rtx,
  input logic        full,
  input logic        afull,
  input logic        empty,
  input logic        aempty,
  input logic [AW:0] w_bin,
  input logic [AW:0] w_gray,
  input logic [AW:0] r_bin
);
  // R10
  wr_full_hold_chk: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (full && wr_en) |=> $stable(w_bin));

  // R11
  rd_empty_hold_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (empty && rd_en && !rtx) |=> $stable(r_bin));

  // R12
  rtx_rewind_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    rtx |=> (r_bin == '0));

  // R7
  full_in_afull_chk: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    full |-> afull);

  // R6
  empty_in_aempty_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    empty |-> aempty);

  // R2
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    $countones(w_gray ^ $past(w_gray)) <= 1);

  // R2
  wr_advance_chk: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wr_en && !full) |=> ((w_bin - $past(w_bin)) == (AW+1)'(1)));
endmodule

bind twoclk_flag_fifo tcf_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wr_en(wr_en), .rd_en(rd_en), .rtx(rtx), .full(full), .afull(afull),
  .empty(empty), .aempty(aempty), .w_bin(w_bin), .w_gray(w_gray),
  .r_bin(r_bin));

// File: tb/twoclk_flag_fifo_test.sv
module twoclk_flag_fifo_test;
  localparam int DW = 18;
  localparam int AW = 11;

  typedef struct packed {
    logic [11:0] nwr;
    logic [11:0] nrd;
    logic [4:0]  flg;  // {empty, aempty, half, afull, full}
  } vec_t;

  // margins 4 (empty) and 8 (full) are loaded before this walk
  localparam vec_t VECS [9] = '{
    '{12'd3,    12'd0,    5'b01000},  // count 3
    '{12'd2,    12'd0,    5'b00000},  // count 5
    '{12'd0,    12'd1,    5'b01000},  // count 4
    '{12'd1021, 12'd0,    5'b00100},  // count 1025
    '{12'd0,    12'd1,    5'b00000},  // count 1024
    '{12'd1016, 12'd0,    5'b00110},  // count 2040
    '{12'd0,    12'd1,    5'b00100},  // count 2039
    '{12'd9,    12'd0,    5'b00111},  // count 2048
    '{12'd0,    12'd2048, 5'b11000}   // count 0
  };

  logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, cfg_ld = 1'b0, cfg_sel = 1'b0;
  logic          rd_en = 1'b0, rd_oe = 1'b1, rtx = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] cfg_val = '0;
  logic [DW-1:0] rd_data;
  logic          empty, aempty, half, afull, full;

  int checks = 0, failures = 0;
  int wr_idx = 0, rd_idx = 0;
  logic done = 1'b0;

  always #4 wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  twoclk_flag_fifo uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .cfg_ld(cfg_ld), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .rd_en(rd_en), .rd_oe(rd_oe), .rtx(rtx), .rd_data(rd_data),
    .empty(empty), .aempty(aempty), .half(half), .afull(afull), .full(full));

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req, input logic [4:0] exp);
    check(req, {27'd0, empty, aempty, half, afull, full}, {27'd0, exp});
  endtask

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
    @(negedge rd_clk);
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rtx = 1'b0; cfg_ld = 1'b0;
    rd_oe = 1'b1;
    repeat (3) @(posedge wr_clk);
    rst_n = 1'b1;
    wr_idx = 0; rd_idx = 0;
    settle();
  endtask

  task automatic do_writes(input int n);
    if (n == 0) return;
    @(negedge wr_clk);
    for (int i = 0; i < n; i++) begin
      wr_data = DW'(wr_idx);
      wr_en   = 1'b1;
      @(negedge wr_clk);
      wr_idx++;
    end
    wr_en = 1'b0;
  endtask

  task automatic do_reads(input string req, input int n);
    if (n == 0) return;
    @(negedge rd_clk);
    rd_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      check(req, {14'd0, rd_data}, {14'd0, DW'(rd_idx)});
      rd_idx++;
    end
    rd_en = 1'b0;
  endtask

  task automatic load_margin(input logic sel, input logic [AW-1:0] val);
    @(negedge wr_clk);
    cfg_ld = 1'b1; cfg_sel = sel; cfg_val = val;
    @(negedge wr_clk);
    cfg_ld = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    do_reset();
    // R5: reset state
    check_flags("R5 reset flags", 5'b11000);
    check("R5 reset data", {14'd0, rd_data}, 32'd0);

    // R9: margins empty=4 (sel 0), full=8 (sel 1)
    load_margin(1'b0, 11'd4);
    load_margin(1'b1, 11'd8);
    settle();

    // vector walk over thresholds: R1 R2 R3 R5 R6 R7 R8
    for (int v = 0; v < 9; v++) begin
      do_writes(int'(VECS[v].nwr));
      do_reads("R3 read order", int'(VECS[v].nrd));
      settle();
      check_flags("R1 R2 R5 R6 R7 R8 flags", VECS[v].flg);
    end

    // R10: write while full is ignored
    do_reset();
    do_writes(2048);
    settle();
    check_flags("R1 full after 2048", 5'b00111);
    @(negedge wr_clk);
    wr_data = 18'h2AAAA; wr_en = 1'b1;
    @(negedge wr_clk);
    wr_en = 1'b0;
    settle();
    check_flags("R10 still full", 5'b00111);
    do_reads("R10 sequence intact", 2048);
    settle();
    check_flags("R10 no extra word", 5'b11000);

    // R11: read while empty is ignored
    held = rd_data;
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_en = 1'b0;
    check("R11 data held", {14'd0, rd_data}, {14'd0, held});
    settle();
    check_flags("R11 still empty", 5'b11000);
    do_writes(1);
    settle();
    do_reads("R11 pointer intact", 1);

    // R4: output enable gating
    @(negedge rd_clk);
    rd_oe = 1'b0;
    #1;
    check("R4 oe low", {14'd0, rd_data}, 32'd0);
    rd_oe = 1'b1;
    #1;
    check("R4 oe high", {14'd0, rd_data}, 32'd2048);

    // R9: default margins of 127
    do_reset();
    do_writes(127);
    settle();
    check("R9 default empty margin at 127", {31'd0, aempty}, 32'd1);
    do_writes(1);
    settle();
    check("R9 default empty margin at 128", {31'd0, aempty}, 32'd0);
    do_writes(1792);
    settle();
    check("R9 default full margin at 1920", {31'd0, afull}, 32'd0);
    do_writes(1);
    settle();
    check("R9 default full margin at 1921", {31'd0, afull}, 32'd1);
    load_margin(1'b1, 11'd0);
    settle();
    check("R9 full margin loaded 0", {31'd0, afull}, 32'd0);

    // R12: retransmit replays from the first word
    do_reset();
    do_writes(5);
    settle();
    do_reads("R12 first pass", 5);
    settle();
    check("R12 drained", {31'd0, empty}, 32'd1);
    @(negedge rd_clk);
    rtx = 1'b1;
    @(negedge rd_clk);
    rtx = 1'b0;
    settle();
    check("R12 data visible again", {31'd0, empty}, 32'd0);
    rd_idx = 0;
    do_reads("R12 replay", 5);
    settle();
    check("R12 drained again", {31'd0, empty}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule